// File: doc/BRIEF.md
# Decade Johnson Counter with One-Hot Decode

This block divides a slow count input by ten. A five-bit twisted ring shifts one place per count. Ten decode outputs come from that ring and exactly one of them is high in each count slot. A carry output is high for the first half of the ten counts and low for the second half, so it gives a square wave at one tenth of the count rate.

The block runs entirely on one system clock. The count input and the inhibit input are treated as slow asynchronous levels: each passes through a synchronizer, and the block advances the ring on their edges. A rising count edge advances the ring while inhibit is low. A falling inhibit edge advances it while the count input is high, so inhibit can also serve as a negative-edge count input.

An asynchronous active-high reset forces the zero slot. Any ring value outside the ten legal codes returns to the zero slot on the next advance. A synchronous load port writes any raw five-bit value into the ring, so that recovery from corrupted values can be exercised.

Top module: `decade_ring_counter`

## Requirements
- R1: While `rst` is high, `slot` equals 10'b0000000001 and `carry` is 1, whatever the count and inhibit inputs do.
- R2: A rising edge of `cnt_clk` while `cnt_inh` is low advances the count by one slot, and slot 9 wraps to slot 0.
- R3: While `cnt_inh` is high, edges of `cnt_clk` leave `slot` and `carry` unchanged.
- R4: A falling edge of `cnt_inh` while `cnt_clk` is high advances the count by one. A falling edge of `cnt_inh` with `cnt_clk` low, a rising edge of `cnt_inh`, and a falling edge of `cnt_clk` all cause no advance.
- R5: The ring steps through the codes 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 (bit 4 on the left). `slot[k]` is high only for the k-th code, and for any legal code exactly one bit of `slot` is high.
- R6: `carry` is high in slots 0 to 4 and low in slots 5 to 9.
- R7: With `ld_en` high at a `clk` edge, the ring takes `ld_val`, and `slot` decodes the loaded value after that edge.
- R8: An advance from any of the 22 ring values outside the legal list lands in slot 0.
- R9: Both count inputs pass through two-stage synchronizers. A `cnt_clk` rise that is driven between two `clk` edges changes `slot` at the third following `clk` edge, and not earlier.
- R10: A count input that is held high while `rst` is released causes no advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset to slot 0 |
| cnt_clk | input | 1 | Count input, sampled; its rising edge advances |
| cnt_inh | input | 1 | Inhibit level; its falling edge advances while `cnt_clk` is high |
| ld_en | input | 1 | Synchronous raw ring load strobe |
| ld_val | input | 5 | Raw ring value to load |
| slot | output | 10 | One-hot decoded count slot |
| carry | output | 1 | High in slots 0 to 4 |

## Verification
The count is driven through twenty plain clock pulses. This shows that every slot appears in order and wraps, and that the carry splits at slot 5. A second pattern mixes the two inputs: inhibit rising and falling with the count input low and with it high, and count pulses under inhibit. This separates the one edge combination that must advance from the others that must not. All 32 raw ring values are loaded and each is advanced once. This separates decoding of legal codes from recovery out of illegal ones. A single pulse is timed edge by edge to pin the synchronizer latency, and a count input held high through reset release checks that no false edge appears.

// File: rtl/decade_pkg.sv
package decade_pkg;
  parameter int unsigned RING_W  = 5;
  localparam int unsigned SLOT_N = 2 * RING_W;

  typedef logic [RING_W-1:0] ring_t;

  // A legal twisted-ring code has at most one boundary between neighbouring bits.
  function automatic logic ring_is_legal(input ring_t r);
    int unsigned edges;
    edges = 0;
    for (int i = 1; i < RING_W; i++) begin
      edges += 32'(r[i] ^ r[i-1]);
    end
    return edges <= 1;
  endfunction

  // Shift with inverted feedback; an illegal code is forced back to zero.
  function automatic ring_t ring_step(input ring_t r);
    if (!ring_is_legal(r)) return '0;
    return {r[RING_W-2:0], ~r[RING_W-1]};
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ring_state.sv
module ring_state
  import decade_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  ld_en,
  input  ring_t ld_val,
  output ring_t ring,
  output logic  legal
);
  ring_t ring_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        ring_q <= '0;
    else if (ld_en) ring_q <= ld_val;
    else if (adv)   ring_q <= ring_step(ring_q);
  end

  assign ring  = ring_q;
  assign legal = ring_is_legal(ring_q);
endmodule

// File: rtl/slot_decode.sv
module slot_decode
  import decade_pkg::*;
(
  input  ring_t              ring,
  output logic [SLOT_N-1:0]  slot,
  output logic               carry
);
  // Each slot looks at one pair of neighbouring ring bits.
  generate
    for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
      if (k == 0) begin : g_zero
        assign slot[k] = ~ring[RING_W-1] & ~ring[0];
      end else if (k < RING_W) begin : g_fill
        assign slot[k] = ring[k-1] & ~ring[k];
      end else if (k == RING_W) begin : g_full
        assign slot[k] = ring[RING_W-1] & ring[0];
      end else begin : g_drain
        assign slot[k] = ~ring[k-RING_W-1] & ring[k-RING_W];
      end
    end
  endgenerate

  assign carry = ~ring[RING_W-1];
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import decade_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_clk,
  input  logic              cnt_inh,
  input  logic              ld_en,
  input  logic [RING_W-1:0] ld_val,
  output logic [SLOT_N-1:0] slot,
  output logic              carry
);
  localparam int unsigned PRIME_W = SYNC_STAGES + 1;

  logic clk_s, inh_s, clk_d, inh_d;
  logic [PRIME_W-1:0] prime_q;
  logic ck_rise_w, inh_fall_w, adv_w, legal_w;
  ring_t ring_w;

  sync_chain #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .d(cnt_clk), .q(clk_s));
  sync_chain #(.STAGES(SYNC_STAGES)) u_sync_inh (
    .clk(clk), .rst(rst), .d(cnt_inh), .q(inh_s));

  // Previous samples for edge detection; prime_q masks edges until the
  // synchronized values and their delayed copies reflect real inputs.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      clk_d   <= 1'b0;
      inh_d   <= 1'b0;
      prime_q <= '0;
    end else begin
      clk_d   <= clk_s;
      inh_d   <= inh_s;
      prime_q <= {prime_q[PRIME_W-2:0], 1'b1};
    end
  end

  assign ck_rise_w  = clk_s & ~clk_d & ~inh_s;
  assign inh_fall_w = inh_d & ~inh_s & clk_s;
  assign adv_w      = prime_q[PRIME_W-1] & (ck_rise_w | inh_fall_w);

  ring_state u_ring (
    .clk(clk), .rst(rst), .adv(adv_w), .ld_en(ld_en),
    .ld_val(ld_val), .ring(ring_w), .legal(legal_w));

  slot_decode u_dec (
    .ring(ring_w), .slot(slot), .carry(carry));
endmodule

// File: rtl/decade_ring_checker.sv
module decade_ring_checker #(
  parameter int unsigned N = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         adv,
  input logic         ld_en,
  input logic         ring_legal,
  input logic [N-1:0] slot,
  input logic         carry
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |-> (slot == N'(1) && carry)); // R1
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld_en && ring_legal) |=> slot == {$past(slot[N-2:0]), $past(slot[N-1])}); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld_en) |=> $stable(slot) && $stable(carry)); // R3
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> $countones(slot) == 1); // R5
  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> carry == (|slot[N/2-1:0])); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld_en && !ring_legal) |=> slot == N'(1)); // R8
endmodule

bind decade_ring_counter decade_ring_checker #(.N(decade_pkg::SLOT_N)) u_chk (
  .clk(clk), .rst(rst), .adv(adv_w), .ld_en(ld_en),
  .ring_legal(legal_w), .slot(slot), .carry(carry));

// File: tb/tb_decade_ring_counter.sv
module tb_decade_ring_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_clk = 1'b0;
  logic cnt_inh = 1'b0;
  logic ld_en = 1'b0;
  logic [4:0] ld_val = '0;
  logic [9:0] slot;
  logic carry;

  int n_chk = 0;
  int n_err = 0;
  int exp_n = 0;
  bit done = 1'b0;

  // Legal codes in count order, bit 4 on the left.
  logic [4:0] codes [10] = '{5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                             5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};

  decade_ring_counter dut (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .cnt_inh(cnt_inh),
    .ld_en(ld_en), .ld_val(ld_val), .slot(slot), .carry(carry));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int idx);
    logic [9:0] es;
    logic ec;
    es = 10'(1) << idx;
    ec = (idx < 5);
    n_chk++;
    if (slot !== es || carry !== ec) begin
      n_err++;
      $display("FAIL %s: slot=%b carry=%b expected slot=%b carry=%b", req, slot, carry, es, ec);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_clk(input logic v);
    @(negedge clk); cnt_clk = v; settle();
  endtask

  task automatic set_inh(input logic v);
    @(negedge clk); cnt_inh = v; settle();
  endtask

  task automatic pulse();
    set_clk(1'b1); set_clk(1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset state", 0);
    cnt_clk = 1'b1; settle();
    chk("R1 clock edge during reset", 0);
    cnt_clk = 1'b0; settle();
    @(negedge clk); rst = 1'b0;
    settle();
    exp_n = 0;
  endtask

  task automatic t_timing();
    @(negedge clk); cnt_clk = 1'b1;
    @(negedge clk); chk("R9 one edge after input", exp_n);
    @(negedge clk); chk("R9 two edges after input", exp_n);
    @(negedge clk); exp_n = (exp_n + 1) % 10; chk("R9 third edge advance", exp_n);
    set_clk(1'b0);
    chk("R9 single advance per rise", exp_n);
  endtask

  task automatic t_sequence();
    for (int i = 0; i < 20; i++) begin
      pulse();
      exp_n = (exp_n + 1) % 10;
      chk("R2 R5 R6 count step", exp_n);
    end
  endtask

  task automatic t_inhibit();
    set_inh(1'b1);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R3 clock blocked by inhibit", exp_n);
    end
    set_inh(1'b0);
    chk("R4 inhibit fall with clock low", exp_n);
  endtask

  task automatic t_inh_edges();
    set_inh(1'b1);
    set_clk(1'b1);
    chk("R3 clock rise under inhibit", exp_n);
    set_inh(1'b0);
    exp_n = (exp_n + 1) % 10;
    chk("R4 inhibit fall with clock high", exp_n);
    set_clk(1'b0);
    chk("R4 clock fall", exp_n);
    set_clk(1'b1);
    exp_n = (exp_n + 1) % 10;
    chk("R2 clock rise", exp_n);
    set_inh(1'b1);
    chk("R4 inhibit rise with clock high", exp_n);
    set_inh(1'b0);
    exp_n = (exp_n + 1) % 10;
    chk("R4 second inhibit fall", exp_n);
    set_clk(1'b0);
  endtask

  task automatic t_load_all();
    for (int v = 0; v < 32; v++) begin
      int idx;
      idx = -1;
      for (int k = 0; k < 10; k++) if (codes[k] == 5'(v)) idx = k;
      @(negedge clk); ld_en = 1'b1; ld_val = 5'(v);
      @(negedge clk); ld_en = 1'b0;
      if (idx >= 0) chk("R7 legal load decode", idx);
      pulse();
      exp_n = (idx >= 0) ? (idx + 1) % 10 : 0;
      chk(idx >= 0 ? "R7 step after load" : "R8 illegal value recovers", exp_n);
    end
  endtask

  task automatic t_reset_mid();
    pulse(); pulse(); pulse();
    exp_n = (exp_n + 3) % 10;
    chk("R2 before mid reset", exp_n);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk("R1 mid reset", 0);
    set_inh(1'b1); set_clk(1'b1); set_inh(1'b0);
    chk("R1 held through inhibit fall", 0);
    // Count input stays high across release.
    @(negedge clk); rst = 1'b0;
    settle();
    exp_n = 0;
    chk("R10 no count at release", exp_n);
    set_clk(1'b0);
    pulse();
    exp_n = 1;
    chk("R2 count after release", exp_n);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_sequence();
    t_inhibit();
    t_inh_edges();
    t_load_all();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule